// File: doc/BRIEF.md
# Multi-Lane Word Synchronizer

This block sits behind four receive lanes that are already aligned to 10-bit code-group boundaries. It removes the lane-to-lane skew so that four groups leave together as one 40-bit word. The instant at which the lanes are lined up is a synchronization event that software picks with a 2-bit select. The event can be the end of a run of idle ordered sets, a change in disparity between two idle forms, or the alignment control character K28.3.

Each lane writes into a short shift-register FIFO. A per-lane detector flags the selected event. A controller notes how many cycles ago each lane saw its event and then fixes a read tap per lane, so that all four events come out of the FIFOs in the same cycle. After lock the controller checks that every later event still lines up. It drops lock when a later event does not line up, when a byte-sync flag falls, or when the select changes.

Code groups are 10-bit values. Bit 9 is the first bit on the line (a) and bit 0 is the last (j). Lane n occupies bits [10n+9:10n] of `lane_data` and `word_out`.

Controller states:
- `ST_OFF`: some lane lacks byte sync, or the select is 00.
- `ST_SEARCH`: waiting for a first event.
- `ST_GATHER`: collecting events from the remaining lanes inside the window.
- `ST_LOCKED`: the taps are fixed.

Transitions:
- OFF→SEARCH: all four lanes are synced and the select is non-zero.
- SEARCH→LOCKED: all four lanes show the event in the same cycle.
- SEARCH→GATHER: some lanes show the event, but not all.
- GATHER→LOCKED: the last missing lane arrives within the window.
- GATHER→SEARCH: the window expires.
- LOCKED→SEARCH: events at the output are not coincident.
- any→SEARCH: the select changes to another non-zero value.
- any→OFF: a lane loses sync, or the select becomes 00.

Top module: `wsync_word_aligner`

## Requirements
- R1: With `evt_sel`=00 and all four `lane_sync` bits high, the cycle after a clock edge shows the groups sampled at that edge on `word_out` without deskew, with `word_valid`=1 and `not_word_sync`=0.
- R2: With `evt_sel`=11 the event is a K28.3 group in either disparity (10'h0F3 or 10'h30C).
- R3: With `evt_sel`=01 the event is the first group that follows at least four consecutive idle ordered sets, falls on an ordered-set boundary, and is not itself part of an idle set. An idle set is K28.5 (10'h0FA or 10'h305) followed by 10'h296 or 10'h245.
- R4: With `evt_sel`=10 the event is the final group of an idle set K28.5+10'h245 that directly follows an idle set K28.5+10'h296.
- R5: Suppose the events of all lanes arrive within 4 group times of the earliest one. Then lock is reached. If the spread is larger, the attempt is discarded: no lock results, and the search goes on with `not_word_sync`=1.
- R6: At the clock edge that registers the last lane's event, the block locks. From the next cycle onward, `word_out` carries each lane's event group in the same cycle, with `word_valid`=1. Later words stay aligned.
- R7: `not_word_sync` is 1 exactly while all lanes are byte-synced, the select is non-zero and lock is not held. It is never 1 together with `word_valid`.
- R8: One cycle after any `lane_sync` bit is low, both `word_valid` and `not_word_sync` are 0. Once sync returns, the search restarts.
- R9: While locked, events that reach the output on every lane together keep the lock. An event that reaches the output on only some lanes drops the lock one cycle later, giving `word_valid`=0 and `not_word_sync`=1.
- R10: A change of `evt_sel` to another non-zero value while synced restarts the search on the next cycle.
- R11: After reset `word_valid`=0 and `not_word_sync`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Group clock, one code group per lane per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_sel | input | 2 | Synchronization event select: 00 off, 01 idle run end, 10 disparity idle change, 11 K28.3 |
| lane_sync | input | 4 | Per-lane byte-synchronized flags |
| lane_data | input | 40 | Four 10-bit code groups, lane n at [10n+9:10n] |
| word_out | output | 40 | Deskewed word, same lane layout |
| word_valid | output | 1 | Word is aligned (locked) or passed through in mode 00 |
| not_word_sync | output | 1 | Lanes byte-synced but word alignment not held |

## Verification
The assertions assume three things about the inputs. Each lane carries exactly one group per cycle. Byte-sync flags change only between groups. A lane that once shows an event also keeps its FIFO contents, so the tap points at the event that was counted. The bench meets these by driving every input one time unit after the rising edge. Each lane of a scenario carries the same reference stream shifted by a fixed skew, and the fill groups are chosen distinct from every event or idle code, so that no event fires by accident.

// File: rtl/wsync_pkg.sv
`timescale 1ns/1ps
package wsync_pkg;

    localparam int CG_W = 10;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SEARCH = 2'd1,
        ST_GATHER = 2'd2,
        ST_LOCKED = 2'd3
    } ws_state_e;

    typedef enum logic [1:0] {
        EV_NONE      = 2'b00,
        EV_IDLE_RUN  = 2'b01,
        EV_DISP_IDLE = 2'b10,
        EV_ALIGN_K   = 2'b11
    } ev_sel_e;

    localparam logic [CG_W-1:0] K285_NEG = 10'h0FA;
    localparam logic [CG_W-1:0] K285_POS = 10'h305;
    localparam logic [CG_W-1:0] K283_NEG = 10'h0F3;
    localparam logic [CG_W-1:0] K283_POS = 10'h30C;
    localparam logic [CG_W-1:0] IDLE_FLIP = 10'h296;
    localparam logic [CG_W-1:0] IDLE_KEEP = 10'h245;

    function automatic logic is_comma_k(input logic [CG_W-1:0] g);
        return (g == K285_NEG) || (g == K285_POS);
    endfunction

    function automatic logic is_align_k(input logic [CG_W-1:0] g);
        return (g == K283_NEG) || (g == K283_POS);
    endfunction

    function automatic logic is_idle_tail(input logic [CG_W-1:0] g);
        return (g == IDLE_FLIP) || (g == IDLE_KEEP);
    endfunction

endpackage

// File: rtl/wsync_evt_det.sv
`timescale 1ns/1ps
module wsync_evt_det
    import wsync_pkg::*;
#(
    parameter int RUN_LEN = 4
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lane_ok,
    input  logic [1:0]      sel,
    input  logic [CG_W-1:0] grp,
    output logic            evt
);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic          prev_k_q;
    logic [RW-1:0] run_q;
    logic          after_flip_q;

    logic cur_k, set_end, hit_run, hit_disp, hit_k, hit;

    always_comb begin
        cur_k    = is_comma_k(grp);
        set_end  = prev_k_q && is_idle_tail(grp);
        hit_run  = !prev_k_q && !cur_k && (run_q == RW'(RUN_LEN));   // R3
        hit_disp = set_end && (grp == IDLE_KEEP) && after_flip_q;    // R4
        hit_k    = is_align_k(grp);                                  // R2
    end

    always_comb begin
        unique case (ev_sel_e'(sel))
            EV_IDLE_RUN:  hit = hit_run;
            EV_DISP_IDLE: hit = hit_disp;
            EV_ALIGN_K:   hit = hit_k;
            default:      hit = 1'b0;
        endcase
        evt = lane_ok && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_k_q     <= 1'b0;
            run_q        <= '0;
            after_flip_q <= 1'b0;
        end else if (!lane_ok) begin
            prev_k_q     <= 1'b0;
            run_q        <= '0;
            after_flip_q <= 1'b0;
        end else begin
            prev_k_q <= cur_k && !prev_k_q;
            if (set_end) begin
                if (run_q != RW'(RUN_LEN)) run_q <= run_q + 1'b1;
                after_flip_q <= (grp == IDLE_FLIP);
            end else if (!cur_k || prev_k_q) begin
                run_q        <= '0;
                after_flip_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wsync_lane_fifo.sv
`timescale 1ns/1ps
module wsync_lane_fifo
    import wsync_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int TW    = 3
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CG_W-1:0] grp_i,
    input  logic            evt_i,
    input  logic [TW-1:0]   tap,
    output logic [CG_W-1:0] grp_o,
    output logic            evt_o
);
    logic [CG_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0] flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
            flag_q <= '0;
        end else begin
            data_q[0] <= grp_i;
            flag_q[0] <= evt_i;
            for (int i = 1; i < DEPTH; i++) begin
                data_q[i] <= data_q[i-1];
                flag_q[i] <= flag_q[i-1];
            end
        end
    end

    always_comb begin
        grp_o = data_q[tap];
        evt_o = flag_q[tap];
    end

    AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tap <= TW'(DEPTH - 1)); // R6

endmodule

// File: rtl/wsync_ctrl.sv
`timescale 1ns/1ps
module wsync_ctrl
    import wsync_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int MAX_SKEW = 4,
    parameter int TW       = 3
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          lane_sync,
    input  logic [1:0]                sel,
    input  logic [LANES-1:0]          evt_in,
    input  logic [LANES-1:0]          evt_at_tap,
    output logic [LANES-1:0][TW-1:0]  tap,
    output logic                      word_valid,
    output logic                      not_word_sync
);
    ws_state_e               state_q, state_d;
    logic [LANES-1:0]        seen_q, seen_d;
    logic [LANES-1:0][TW-1:0] age_q, age_d;
    logic [LANES-1:0][TW-1:0] tap_q, tap_d;
    logic [TW-1:0]           cnt_q, cnt_d;
    logic [1:0]              sel_q;
    logic                    byp_q;
    logic                    all_sync;

    assign all_sync = &lane_sync;

    always_comb begin
        state_d = state_q;
        seen_d  = seen_q;
        age_d   = age_q;
        cnt_d   = cnt_q;
        tap_d   = tap_q;
        if (!all_sync || sel == EV_NONE) begin
            state_d = ST_OFF;
            seen_d  = '0;
            tap_d   = '0;
        end else if (sel != sel_q) begin
            state_d = ST_SEARCH;
            seen_d  = '0;
            tap_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_SEARCH;
                ST_SEARCH: begin
                    if (|evt_in) begin
                        seen_d = evt_in;
                        age_d  = '0;
                        cnt_d  = '0;
                        if (&evt_in) begin
                            state_d = ST_LOCKED;
                            tap_d   = '0;
                        end else begin
                            state_d = ST_GATHER;
                        end
                    end
                end
                ST_GATHER: begin
                    seen_d = seen_q | evt_in;
                    cnt_d  = cnt_q + 1'b1;
                    for (int i = 0; i < LANES; i++)
                        age_d[i] = seen_q[i] ? age_q[i] + 1'b1 : '0;
                    if (&seen_d) begin
                        state_d = ST_LOCKED;
                        tap_d   = age_d;
                    end else if (cnt_d == TW'(MAX_SKEW)) begin
                        state_d = ST_SEARCH;
                        seen_d  = '0;
                    end
                end
                ST_LOCKED: begin
                    if (|evt_at_tap && !(&evt_at_tap)) begin
                        state_d = ST_SEARCH;
                        seen_d  = '0;
                        tap_d   = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            seen_q  <= '0;
            age_q   <= '0;
            cnt_q   <= '0;
            tap_q   <= '0;
            sel_q   <= EV_NONE;
            byp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
            age_q   <= age_d;
            cnt_q   <= cnt_d;
            tap_q   <= tap_d;
            sel_q   <= sel;
            byp_q   <= all_sync && (sel == EV_NONE);
        end
    end

    always_comb begin
        tap           = tap_q;
        word_valid    = (state_q == ST_LOCKED) || byp_q;
        not_word_sync = (state_q == ST_SEARCH) || (state_q == ST_GATHER);
    end

    AST_GATHER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATHER) |-> (cnt_q < TW'(MAX_SKEW))); // R5

    AST_LOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOCKED && state_d == ST_LOCKED) |=> (&evt_at_tap)); // R6

    AST_MISMATCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && |evt_at_tap && !(&evt_at_tap)) |=> (state_q != ST_LOCKED)); // R9

    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && all_sync && sel != sel_q && sel != EV_NONE) |=> (state_q == ST_SEARCH)); // R10

endmodule

// File: rtl/wsync_word_aligner.sv
`timescale 1ns/1ps
module wsync_word_aligner
    import wsync_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int MAX_SKEW = 4,
    parameter int RUN_LEN  = 4
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              evt_sel,
    input  logic [LANES-1:0]        lane_sync,
    input  logic [LANES*CG_W-1:0]   lane_data,
    output logic [LANES*CG_W-1:0]   word_out,
    output logic                    word_valid,
    output logic                    not_word_sync
);
    localparam int DEPTH = MAX_SKEW + 1;
    localparam int TW    = $clog2(DEPTH);

    logic [LANES-1:0]         evt_raw;
    logic [LANES-1:0]         evt_tap;
    logic [LANES-1:0][TW-1:0] tap;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wsync_evt_det #(.RUN_LEN(RUN_LEN)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .lane_ok (lane_sync[g]),
            .sel     (evt_sel),
            .grp     (lane_data[g*CG_W +: CG_W]),
            .evt     (evt_raw[g])
        );
        wsync_lane_fifo #(.DEPTH(DEPTH), .TW(TW)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .grp_i (lane_data[g*CG_W +: CG_W]),
            .evt_i (evt_raw[g]),
            .tap   (tap[g]),
            .grp_o (word_out[g*CG_W +: CG_W]),
            .evt_o (evt_tap[g])
        );
    end

    wsync_ctrl #(.LANES(LANES), .MAX_SKEW(MAX_SKEW), .TW(TW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane_sync     (lane_sync),
        .sel           (evt_sel),
        .evt_in        (evt_raw),
        .evt_at_tap    (evt_tap),
        .tap           (tap),
        .word_valid    (word_valid),
        .not_word_sync (not_word_sync)
    );

    AST_SYNC_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_sync) |=> (!word_valid && !not_word_sync)); // R8

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && not_word_sync)); // R7

endmodule

// File: tb/wsync_word_aligner_test.sv
`timescale 1ns/1ps
module wsync_word_aligner_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  evt_sel = 2'b00;
    logic [3:0]  lane_sync = 4'h0;
    logic [39:0] lane_data = '0;
    logic [39:0] word_out;
    logic        word_valid, not_word_sync;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    wsync_word_aligner uut (
        .clk(clk), .rst_n(rst_n), .evt_sel(evt_sel), .lane_sync(lane_sync),
        .lane_data(lane_data), .word_out(word_out), .word_valid(word_valid),
        .not_word_sync(not_word_sync)
    );

    // rows: sel[14:13], skew lane0..3 in 3-bit fields from [12:10] down, lock expected [0]
    localparam int NROWS = 7;
    localparam logic [14:0] VEC [NROWS] = '{
        {2'b11, 3'd0, 3'd0, 3'd0, 3'd0, 1'b1},
        {2'b11, 3'd0, 3'd1, 3'd2, 3'd3, 1'b1},
        {2'b11, 3'd4, 3'd0, 3'd2, 3'd1, 1'b1},
        {2'b11, 3'd0, 3'd5, 3'd1, 3'd2, 1'b0},
        {2'b01, 3'd2, 3'd0, 3'd3, 3'd1, 1'b1},
        {2'b10, 3'd1, 3'd3, 3'd0, 3'd0, 1'b1},
        {2'b01, 3'd0, 3'd0, 3'd5, 3'd0, 1'b0}
    };

    localparam logic [39:0] FILL = {4{10'h1F0}};

    task automatic check(input string req, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] s, input logic [3:0] y, input logic [39:0] d);
        evt_sel = s; lane_sync = y; lane_data = d;
        @(posedge clk); #1;
    endtask

    function automatic int ev_idx(input int mode);
        if (mode == 1) return 12;
        if (mode == 2) return 7;
        return 4;
    endfunction

    function automatic logic [9:0] base(input int mode, input int n);
        if (n < 0) return 10'h1F0;
        if (n < 4) return 10'(256 + n);
        if (mode == 3 && n == 4) return 10'h0F3;
        if (mode == 1 && n < 12) return (n % 2 == 0) ? 10'h0FA : 10'h245;
        if (mode == 2 && n == 4) return 10'h305;
        if (mode == 2 && n == 5) return 10'h296;
        if (mode == 2 && n == 6) return 10'h0FA;
        if (mode == 2 && n == 7) return 10'h245;
        return 10'(256 + n);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11", "reset valid", {39'b0, word_valid}, 40'd0);
        check("R11", "reset nws", {39'b0, not_word_sync}, 40'd0);
        rst_n = 1'b1;

        // R1 bypass
        step(2'b00, 4'hF, 40'h12_3456_789A);
        check("R1", "bypass data", word_out, 40'h12_3456_789A);
        check("R1", "bypass valid", {39'b0, word_valid}, 40'd1);
        step(2'b00, 4'hF, {10'h0F3, 10'h111, 10'h0F3, 10'h222});
        check("R1", "bypass no deskew", word_out, {10'h0F3, 10'h111, 10'h0F3, 10'h222});
        check("R1", "bypass nws", {39'b0, not_word_sync}, 40'd0);

        // table of skew scenarios: R2 R3 R4 R5 R6 R7
        for (int r = 0; r < NROWS; r++) begin
            logic [1:0] s;
            int sk [4];
            int maxs;
            int e;
            int mode;
            logic lk;
            s = VEC[r][14:13];
            mode = int'(s);
            lk = VEC[r][0];
            maxs = 0;
            for (int i = 0; i < 4; i++) begin
                sk[i] = int'(VEC[r][12-3*i -: 3]);
                if (sk[i] > maxs) maxs = sk[i];
            end
            e = ev_idx(mode);
            step(s, 4'h0, FILL);
            step(s, 4'hF, FILL);
            for (int t = 0; t < e + maxs + 6; t++) begin
                logic [39:0] d;
                for (int i = 0; i < 4; i++) d[i*10 +: 10] = base(mode, t - sk[i]);
                step(s, 4'hF, d);
                if (lk && t == e + maxs - 1) begin
                    check("R7", "nws before lock", {39'b0, not_word_sync}, 40'd1);
                    check("R7", "not yet valid", {39'b0, word_valid}, 40'd0);
                end
                if (lk && t == e + maxs) begin
                    check(mode == 3 ? "R2" : (mode == 1 ? "R3" : "R4"), "lock valid",
                          {39'b0, word_valid}, 40'd1);
                    check("R6", "events coincide", word_out, {4{base(mode, e)}});
                end
                if (lk && t == e + maxs + 3)
                    check("R6", "stays aligned", word_out, {4{base(mode, e + 3)}});
            end
            if (lk) begin
                check("R5", "lock held in window", {39'b0, word_valid}, 40'd1);
            end else begin
                check("R5", "spread too large no lock", {39'b0, word_valid}, 40'd0);
                check("R5", "still searching", {39'b0, not_word_sync}, 40'd1);
            end
        end

        // R8 loss of byte sync
        step(2'b11, 4'h0, FILL);
        step(2'b11, 4'hF, FILL);
        step(2'b11, 4'hF, {10'h30C, 10'h0F3, 10'h30C, 10'h0F3});
        check("R2", "both disparities lock", {39'b0, word_valid}, 40'd1);
        step(2'b11, 4'b1011, FILL);
        check("R8", "valid cleared", {39'b0, word_valid}, 40'd0);
        check("R8", "nws cleared", {39'b0, not_word_sync}, 40'd0);
        step(2'b11, 4'hF, FILL);
        check("R8", "search restarts", {39'b0, not_word_sync}, 40'd1);

        // R9 coincident events keep lock, partial event drops it
        step(2'b11, 4'hF, {4{10'h0F3}});
        step(2'b11, 4'hF, FILL);
        step(2'b11, 4'hF, {4{10'h0F3}});
        step(2'b11, 4'hF, FILL);
        step(2'b11, 4'hF, FILL);
        check("R9", "coincident keeps lock", {39'b0, word_valid}, 40'd1);
        step(2'b11, 4'hF, {10'h1F0, 10'h1F0, 10'h1F0, 10'h0F3});
        check("R9", "valid until seen", {39'b0, word_valid}, 40'd1);
        step(2'b11, 4'hF, FILL);
        check("R9", "partial drops lock", {39'b0, word_valid}, 40'd0);
        check("R9", "nws after drop", {39'b0, not_word_sync}, 40'd1);

        // R10 select change restarts
        step(2'b11, 4'hF, {4{10'h0F3}});
        check("R10", "relocked", {39'b0, word_valid}, 40'd1);
        step(2'b01, 4'hF, FILL);
        check("R10", "restart valid", {39'b0, word_valid}, 40'd0);
        check("R10", "restart nws", {39'b0, not_word_sync}, 40'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule